// File: doc/BRIEF.md
# Single-Path Trigger Crossing with Parameter Capture

This block moves a start request from a host clock domain into an independent destination clock domain. The host first sets a generator-select mask and a 16-bit seed word on quasi-static wires. It then raises a one-cycle trigger. Only that one trigger bit crosses the boundary. In the host domain the trigger becomes a level toggle. The toggle passes through a flop synchronizer, and in the destination domain it is turned back into a single-cycle pulse.

On the recovered pulse, and only on that cycle, the destination side samples the mask and the seed. It then drives one start strobe on every selected generator line, all in the same destination cycle, and presents the captured seed beside them. A zero seed cannot be used by a linear-feedback generator. When the captured seed is zero, the block flags an error and issues no strobes. The destination returns an acknowledge toggle to the host. Until that toggle comes back, the host side reports busy and ignores further triggers. During that time the host must keep the mask and seed wires unchanged.

Top module: `trigx_top`

## Requirements
- R1: After reset of both domains, `d_start` is all zero, `d_seed_err` is 0, `d_seed` is zero and `h_busy` is 0.
- R2: A trigger accepted with a nonzero seed and a nonzero mask produces exactly one destination cycle in which `d_start` equals the mask. Every selected bit is high in that one cycle, and each strobe lasts exactly one destination cycle.
- R3: On every accepted trigger, `d_seed` takes the host seed value at the capture cycle and holds it until the next accepted trigger. Whenever any `d_start` bit is high, `d_seed` is nonzero.
- R4: `h_busy` is high in the host cycle after an accepted trigger. It stays high until the acknowledge returns, and it falls within a bounded number of host cycles.
- R5: A trigger raised while `h_busy` is high is ignored. It produces no strobe, no error and no seed update.
- R6: An accepted trigger with a zero seed gives a one-cycle pulse on `d_seed_err` and no `d_start` bit. `d_seed_err` and `d_start` are never active together.
- R7: An accepted trigger with a nonzero seed and an all-zero mask produces no strobe and no error, but it still updates `d_seed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host domain clock |
| hrst | input | 1 | Host domain synchronous reset, active high |
| h_trig | input | 1 | One-cycle start request from host |
| h_mask | input | N_GEN | Generator select wires, held while busy |
| h_seed | input | 16 | Seed wires, held while busy |
| h_busy | output | 1 | Crossing in flight; triggers are ignored |
| dclk | input | 1 | Destination domain clock |
| drst | input | 1 | Destination domain synchronous reset, active high |
| d_start | output | N_GEN | Per-generator start strobes, cycle aligned |
| d_seed | output | 16 | Seed captured with the last trigger |
| d_seed_err | output | 1 | One-cycle pulse: captured seed was zero |

## Verification
The bench goes after split strobes. If the mask bits reached the destination on separate paths or were sampled over two cycles, the bench would see a partial mask followed by a second event. It fires a second trigger while a crossing is still in flight. A block without the busy lockout would toggle again and produce a duplicate start. Zero-seed and empty-mask triggers are mixed with random ones. A design that strobed on a zero seed, flagged an empty mask, or skipped the seed update would show a wrong event count or a stale `d_seed`.

// File: rtl/trigx_pkg.sv
package trigx_pkg;

    localparam int unsigned SEED_W = 16;

    typedef logic [SEED_W-1:0] seed_t;

    // Outcome of one recovered trigger in the destination domain
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_START   = 2'd1,
        EV_SEEDERR = 2'd2,
        EV_EMPTY   = 2'd3
    } dst_event_e;

    typedef struct packed {
        seed_t      seed;
        dst_event_e ev;
    } capture_t;

    // A zero seed would lock a linear-feedback generator
    function automatic logic seed_usable(seed_t s);
        return (s != '0);
    endfunction

    function automatic dst_event_e classify(logic any_sel, seed_t s);
        if (!seed_usable(s))
            return EV_SEEDERR;
        else if (!any_sel)
            return EV_EMPTY;
        else
            return EV_START;
    endfunction

endpackage

// File: rtl/trigx_sync.sv
module trigx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trigx_host.sv
module trigx_host (
    input  logic hclk,
    input  logic hrst,
    input  logic trig,
    input  logic ack_tgl_s,
    output logic req_tgl,
    output logic busy
);
    // Request and returned acknowledge differ while a crossing is in flight
    assign busy = req_tgl ^ ack_tgl_s;

    always_ff @(posedge hclk) begin
        if (hrst)
            req_tgl <= 1'b0;
        else if (trig && !busy)
            req_tgl <= ~req_tgl;
    end
endmodule

// File: rtl/trigx_dest.sv
module trigx_dest
    import trigx_pkg::*;
#(
    parameter int unsigned N_GEN = 8
) (
    input  logic             dclk,
    input  logic             drst,
    input  logic             req_tgl_s,
    input  logic [N_GEN-1:0] mask,
    input  seed_t            seed,
    output logic [N_GEN-1:0] start,
    output seed_t            seed_q,
    output logic             seed_err,
    output logic             ack_tgl
);
    logic     req_d;
    logic     pulse;
    capture_t cap;

    assign pulse   = req_tgl_s ^ req_d;
    assign ack_tgl = req_d;

    // Mask and seed are only looked at on the recovered pulse cycle
    always_comb begin
        cap.seed = seed;
        cap.ev   = pulse ? classify(|mask, seed) : EV_NONE;
    end

    always_ff @(posedge dclk) begin
        if (drst) begin
            req_d    <= 1'b0;
            start    <= '0;
            seed_err <= 1'b0;
            seed_q   <= '0;
        end else begin
            req_d    <= req_tgl_s;
            start    <= '0;
            seed_err <= 1'b0;
            if (pulse) begin
                seed_q <= cap.seed;
                unique case (cap.ev)
                    EV_START:   start    <= mask;
                    EV_SEEDERR: seed_err <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trigx_top.sv
module trigx_top
    import trigx_pkg::*;
#(
    parameter int unsigned N_GEN       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             hclk,
    input  logic             hrst,
    input  logic             h_trig,
    input  logic [N_GEN-1:0] h_mask,
    input  logic [SEED_W-1:0] h_seed,
    output logic             h_busy,
    input  logic             dclk,
    input  logic             drst,
    output logic [N_GEN-1:0] d_start,
    output logic [SEED_W-1:0] d_seed,
    output logic             d_seed_err
);
    logic req_tgl, req_tgl_s;
    logic ack_tgl, ack_tgl_s;

    trigx_host host_i (
        .hclk      (hclk),
        .hrst      (hrst),
        .trig      (h_trig),
        .ack_tgl_s (ack_tgl_s),
        .req_tgl   (req_tgl),
        .busy      (h_busy)
    );

    // The single crossing path into the destination domain
    trigx_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk (dclk),
        .rst (drst),
        .d   (req_tgl),
        .q   (req_tgl_s)
    );

    trigx_dest #(.N_GEN(N_GEN)) dest_i (
        .dclk      (dclk),
        .drst      (drst),
        .req_tgl_s (req_tgl_s),
        .mask      (h_mask),
        .seed      (h_seed),
        .start     (d_start),
        .seed_q    (d_seed),
        .seed_err  (d_seed_err),
        .ack_tgl   (ack_tgl)
    );

    trigx_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk (hclk),
        .rst (hrst),
        .d   (ack_tgl),
        .q   (ack_tgl_s)
    );
endmodule

// File: rtl/trigx_chk.sv
module trigx_chk #(
    parameter int unsigned N_GEN = 8
) (
    input logic             hclk,
    input logic             hrst,
    input logic             h_trig,
    input logic             h_busy,
    input logic             dclk,
    input logic             drst,
    input logic [N_GEN-1:0] d_start,
    input logic [15:0]      d_seed,
    input logic             d_seed_err
);
    // R2: every strobe is a single destination cycle
    p_strobe_one_cycle_r2: assert property (@(posedge dclk) disable iff (drst)
        (d_start != '0) |=> (d_start == '0));

    // R3: strobes always come with a usable seed
    p_seed_nonzero_r3: assert property (@(posedge dclk) disable iff (drst)
        (d_start != '0) |-> (d_seed != '0));

    // R4: an accepted trigger makes busy visible next host cycle
    p_busy_after_trig_r4: assert property (@(posedge hclk) disable iff (hrst)
        (h_trig && !h_busy) |=> h_busy);

    // R6: error excludes strobes
    p_err_excl_r6: assert property (@(posedge dclk) disable iff (drst)
        d_seed_err |-> (d_start == '0));

    // R6: error is a one-cycle pulse
    p_err_pulse_r6: assert property (@(posedge dclk) disable iff (drst)
        d_seed_err |=> !d_seed_err);
endmodule

bind trigx_top trigx_chk #(.N_GEN(N_GEN)) chk_i (
    .hclk       (hclk),
    .hrst       (hrst),
    .h_trig     (h_trig),
    .h_busy     (h_busy),
    .dclk       (dclk),
    .drst       (drst),
    .d_start    (d_start),
    .d_seed     (d_seed),
    .d_seed_err (d_seed_err)
);

// File: tb/trigx_top_tb_top.sv
`timescale 1ns/1ps
module trigx_top_tb_top;
    localparam int N_GEN = 8;

    logic             hclk = 1'b0;
    logic             dclk = 1'b0;
    logic             hrst = 1'b1;
    logic             drst = 1'b1;
    logic             h_trig = 1'b0;
    logic [N_GEN-1:0] h_mask = '0;
    logic [15:0]      h_seed = '0;
    logic             h_busy;
    logic [N_GEN-1:0] d_start;
    logic [15:0]      d_seed;
    logic             d_seed_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // destination-side monitor state
    int             ev_cnt = 0;
    int             err_cnt = 0;
    int             wide_cnt = 0;
    bit             prev_start = 0;
    bit             prev_err = 0;
    logic [N_GEN-1:0] last_start = '0;
    logic [15:0]    last_seed = '0;

    always #4 dclk = ~dclk;   // 125 MHz destination clock
    always #5 hclk = ~hclk;   // unrelated host clock

    trigx_top #(.N_GEN(N_GEN)) dut_i (
        .hclk(hclk), .hrst(hrst), .h_trig(h_trig), .h_mask(h_mask),
        .h_seed(h_seed), .h_busy(h_busy), .dclk(dclk), .drst(drst),
        .d_start(d_start), .d_seed(d_seed), .d_seed_err(d_seed_err)
    );

    always @(negedge dclk) begin
        if (!drst) begin
            if (d_start != '0) begin
                ev_cnt++;
                last_start = d_start;
                last_seed  = d_seed;
                if (prev_start) wide_cnt++;
            end
            if (d_seed_err) begin
                err_cnt++;
                if (prev_err) wide_cnt++;
                if (d_start != '0) wide_cnt++;
            end
            prev_start = (d_start != '0);
            prev_err   = d_seed_err;
        end
    end

    function automatic int exp_events(logic [N_GEN-1:0] m, logic [15:0] s);
        return (s != 0 && m != 0) ? 1 : 0;
    endfunction

    function automatic int exp_errors(logic [15:0] s);
        return (s == 0) ? 1 : 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fire(logic [N_GEN-1:0] m, logic [15:0] s, bit extra);
        int ev0, er0, waited;
        ev0 = ev_cnt;
        er0 = err_cnt;
        @(negedge hclk);
        h_mask = m;
        h_seed = s;
        @(negedge hclk);
        h_trig = 1'b1;
        @(negedge hclk);
        h_trig = 1'b0;
        check(h_busy == 1'b1, "R4", "busy after trigger", int'(h_busy), 1);
        if (extra) begin
            // R5: second trigger while in flight, different wires are not allowed, same ones kept
            h_trig = 1'b1;
            @(negedge hclk);
            h_trig = 1'b0;
        end
        waited = 0;
        while (h_busy && waited < 60) begin
            @(negedge hclk);
            waited++;
        end
        check(h_busy == 1'b0, "R4", "busy clears", int'(h_busy), 0);
        repeat (20) @(negedge dclk);
        check(ev_cnt - ev0 == exp_events(m, s), extra ? "R5" : "R2",
              "strobe events", ev_cnt - ev0, exp_events(m, s));
        check(err_cnt - er0 == exp_errors(s), s == 0 ? "R6" : "R7",
              "error pulses", err_cnt - er0, exp_errors(s));
        if (exp_events(m, s) == 1) begin
            check(last_start == m, "R2", "strobe mask", int'(last_start), int'(m));
            check(last_seed == s, "R3", "seed at strobe", int'(last_seed), int'(s));
        end
        check(d_seed == s, (m == 0 && s != 0) ? "R7" : "R3", "held seed", int'(d_seed), int'(s));
    endtask

    initial begin
        #500us;
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        repeat (10) @(negedge hclk);
        hrst = 1'b0;
        drst = 1'b0;
        repeat (4) @(negedge dclk);
        // R1: reset state
        check(d_start == '0, "R1", "start after reset", int'(d_start), 0);
        check(d_seed_err == 1'b0, "R1", "err after reset", int'(d_seed_err), 0);
        check(d_seed == '0, "R1", "seed after reset", int'(d_seed), 0);
        check(h_busy == 1'b0, "R1", "busy after reset", int'(h_busy), 0);

        // directed corners
        fire(8'hFF, 16'hACE1, 1'b0);   // all generators at once (R2)
        fire(8'h01, 16'h0001, 1'b0);   // single generator, smallest seed
        fire(8'h5A, 16'h0000, 1'b0);   // zero seed (R6)
        fire(8'h00, 16'hBEEF, 1'b0);   // empty mask (R7)
        fire(8'h81, 16'hFFFF, 1'b1);   // extra trigger while busy (R5)
        fire(8'h3C, 16'h0000, 1'b1);   // zero seed with ignored retrigger

        for (int i = 0; i < 40; i++) begin
            logic [N_GEN-1:0] m;
            logic [15:0]      s;
            m = N_GEN'($urandom);
            s = 16'($urandom);
            if (i % 7 == 3) s = '0;
            if (i % 5 == 2) m = '0;
            fire(m, s, ($urandom % 3) == 0);
        end

        check(wide_cnt == 0, "R2", "strobe/err width violations", wide_cnt, 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule